// File: doc/BRIEF.md
# Receive Lock Error Monitor with Sticky Hold

This block sits behind a serial audio stream receiver. It watches two conditions from the recovery logic: whether any stream is present, and whether the frame decoder holds frame lock. From these it drives one error flag. The receiver marks each recovered word period with a one-cycle tick. The error flag clears only after a long run of consecutive fault-free word periods, so downstream logic never acts on a stream that has only just settled. A single bad cycle sends the flag high again and restarts the run.

A hold input makes the flag sticky. While hold is high, an error that has been raised stays raised even after the stream has requalified. It clears only once the stream is good and hold has been taken low. The same error state gates a set of outgoing clocks. Each clock output is its source ANDed with a per-clock enable, and that enable may change only while its source is low. A converter fed by these clocks therefore sees no runaway clock and no truncated pulse.

Top module: `lock_error_monitor`

## Requirements
- R1: After the asynchronous reset, and in the cycle after a synchronous reset (`srst_i` high at a clock edge), `err_o` is 1 and every `clk_gated_o` bit is 0. The qualification run is also cleared, so a full new run is needed.
- R2: If `stream_present_i` is 0 or `frame_lock_i` is 0 at a clock edge, `err_o` is 1 after that edge.
- R3: Starting from the error state, `err_o` goes low at the edge that takes the QUAL_WORDS-th consecutive `word_tick_i` with no fault in between, and not earlier (hold low).
- R4: One fault cycle at any point in a partial run discards the run; QUAL_WORDS further clean ticks are needed.
- R5: While `hold_i` is 1, a raised `err_o` stays 1 whatever the stream does. Once the stream is qualified, `err_o` falls at the first edge that samples `hold_i` at 0.
- R6: With `hold_i` at 0, `err_o` follows the stream: it rises on a fault and falls again after a new qualifying run.
- R7: `clk_gated_o[i]` equals `clk_src_i[i]` AND an enable. The enable changes only at edges where `clk_src_i[i]` is 0, and it is set to the inverse of `err_o`. A gated output therefore rises only with its source and falls only with its source, and it is low from the edge after `err_o` is 1 with the source low.
- R8: `srst_i` discards a completed or partial run. After it, QUAL_WORDS clean ticks are needed again.
- R9: Once qualified, further clean ticks keep `err_o` at 0; the run count saturates and does not wrap.
- R10: With no fault and no `word_tick_i`, the run does not advance and `err_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Monitor clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous reset, active high |
| word_tick_i | input | 1 | One-cycle pulse per recovered word period |
| stream_present_i | input | 1 | 1 while an input stream is detected |
| frame_lock_i | input | 1 | 1 while the frame decoder is locked |
| hold_i | input | 1 | 1 makes a raised error sticky |
| clk_src_i | input | N_CLK | Output clocks before gating, as sampled levels |
| err_o | output | 1 | Error flag, 1 = outputs invalid |
| clk_gated_o | output | N_CLK | Gated output clocks |

## Verification
The bench uses a qualification length of five ticks and sweeps the position of a single fault across every point of a partial run. An off-by-one in the run counter shows up as a release one tick early or late, and a counter that fails to clear lets the flag fall too soon. The sticky hold is checked by keeping hold high past qualification and then dropping it, both before and after the run completes; a latch that ignored hold would release at once, and one that ignored the fault would release while the stream is still bad. On every cycle the gated clocks are compared against their sources. Enable changes made while a source is high would show up as a gated edge with no matching source edge.

// File: rtl/lock_mon_pkg.sv
package lock_mon_pkg;

  typedef enum logic [1:0] {
    RUN_FAULT = 2'd0,
    RUN_COUNT = 2'd1,
    RUN_DONE  = 2'd2
  } run_state_e;

  function automatic int unsigned run_cnt_w(int unsigned words);
    return (words < 2) ? 1 : $clog2(words + 1);
  endfunction

endpackage

// File: rtl/lock_qual_counter.sv
module lock_qual_counter
  import lock_mon_pkg::*;
#(
  parameter int unsigned QUAL_WORDS = 3900
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic fault_i,
  input  logic tick_i,
  output logic qual_next_o
);
  localparam int unsigned CW = run_cnt_w(QUAL_WORDS);
  localparam logic [CW-1:0] LIMIT = CW'(QUAL_WORDS);

  logic [CW-1:0] cnt_q, cnt_d;
  run_state_e    state;

  always_comb begin
    if (cnt_q == LIMIT)        state = RUN_DONE;
    else if (cnt_q == '0)      state = RUN_FAULT;
    else                       state = RUN_COUNT;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i || fault_i)                 cnt_d = '0;
    else if (tick_i && state != RUN_DONE) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign qual_next_o = (cnt_d == LIMIT);

endmodule

// File: rtl/lock_err_latch.sv
module lock_err_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic qual_next_i,
  input  logic hold_i,
  output logic err_o
);
  logic err_q, err_d;

  // sticky while hold is high; release needs qualified stream and hold low
  always_comb begin
    if (clr_i) err_d = 1'b1;
    else       err_d = !qual_next_i || (err_q && hold_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b1;
    else         err_q <= err_d;
  end

  assign err_o = err_q;

endmodule

// File: rtl/lock_clk_gate.sv
module lock_clk_gate #(
  parameter int unsigned N_CLK = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             err_i,
  input  logic [N_CLK-1:0] src_i,
  output logic [N_CLK-1:0] gated_o
);
  for (genvar g = 0; g < N_CLK; g++) begin : g_gate
    logic en_q;
    // enable moves only while its source is low
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        en_q <= 1'b0;
      else if (clr_i)     en_q <= 1'b0;
      else if (!src_i[g]) en_q <= !err_i;
    end
    assign gated_o[g] = src_i[g] & en_q;
  end

endmodule

// File: rtl/lock_error_monitor.sv
module lock_error_monitor #(
  parameter int unsigned QUAL_WORDS = 3900,
  parameter int unsigned N_CLK      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             word_tick_i,
  input  logic             stream_present_i,
  input  logic             frame_lock_i,
  input  logic             hold_i,
  input  logic [N_CLK-1:0] clk_src_i,
  output logic             err_o,
  output logic [N_CLK-1:0] clk_gated_o
);
  logic fault, qual_next;

  assign fault = !stream_present_i || !frame_lock_i;

  lock_qual_counter #(.QUAL_WORDS(QUAL_WORDS)) u_qual (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (srst_i),
    .fault_i     (fault),
    .tick_i      (word_tick_i),
    .qual_next_o (qual_next)
  );

  lock_err_latch u_err (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (srst_i),
    .qual_next_i (qual_next),
    .hold_i      (hold_i),
    .err_o       (err_o)
  );

  lock_clk_gate #(.N_CLK(N_CLK)) u_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (srst_i),
    .err_i   (err_o),
    .src_i   (clk_src_i),
    .gated_o (clk_gated_o)
  );

endmodule

// File: rtl/lock_error_monitor_chk.sv
module lock_error_monitor_chk #(
  parameter int unsigned QUAL_WORDS = 3900,
  parameter int unsigned N_CLK      = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             srst_i,
  input logic             word_tick_i,
  input logic             stream_present_i,
  input logic             frame_lock_i,
  input logic             hold_i,
  input logic [N_CLK-1:0] clk_src_i,
  input logic             err_o,
  input logic [N_CLK-1:0] clk_gated_o
);
  localparam int unsigned RW = $clog2(QUAL_WORDS + 2);

  logic [RW-1:0] run_q;
  logic          bad;

  assign bad = !stream_present_i || !frame_lock_i;

  // independent count of clean ticks since the last fault or reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           run_q <= '0;
    else if (srst_i || bad)                run_q <= '0;
    else if (word_tick_i && run_q < RW'(QUAL_WORDS)) run_q <= run_q + 1'b1;
  end

  a_r1_sync_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (err_o && clk_gated_o == '0));

  a_r2_fault_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad |=> err_o);

  a_r3_release_after_full_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_o) |-> (run_q == RW'(QUAL_WORDS)));

  a_r5_hold_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && hold_i) |=> err_o);

  for (genvar g = 0; g < N_CLK; g++) begin : g_clk
    a_r7_rise_with_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(clk_gated_o[g]) |-> $rose(clk_src_i[g]));
    a_r7_fall_with_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(clk_gated_o[g]) |-> ($fell(clk_src_i[g]) || $past(srst_i)));
    a_r7_err_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (err_o && !clk_src_i[g]) |=> !clk_gated_o[g]);
  end

endmodule

bind lock_error_monitor lock_error_monitor_chk #(
  .QUAL_WORDS(QUAL_WORDS),
  .N_CLK     (N_CLK)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .srst_i           (srst_i),
  .word_tick_i      (word_tick_i),
  .stream_present_i (stream_present_i),
  .frame_lock_i     (frame_lock_i),
  .hold_i           (hold_i),
  .clk_src_i        (clk_src_i),
  .err_o            (err_o),
  .clk_gated_o      (clk_gated_o)
);

// File: tb/lock_error_monitor_test.sv
`timescale 1ns/1ps
module lock_error_monitor_test;
  localparam int Q = 5;
  localparam int N = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic srst = 1'b0, tick = 1'b0, pres = 1'b0, lock = 1'b0, hold = 1'b0;
  logic [N-1:0] src = '0;
  logic err;
  logic [N-1:0] gclk;
  int total = 0, bad = 0, cyc_n = 0;
  int phase = 0;

  always #4 clk = ~clk;

  lock_error_monitor #(.QUAL_WORDS(Q), .N_CLK(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .srst_i(srst), .word_tick_i(tick),
    .stream_present_i(pres), .frame_lock_i(lock), .hold_i(hold),
    .clk_src_i(src), .err_o(err), .clk_gated_o(gclk));

  // source clocks: bit0 period 2 cycles, bit1 period 4 cycles
  always @(negedge clk) begin
    #2;
    phase++;
    src[0] = ~src[0];
    if (phase % 2 == 0) src[1] = ~src[1];
  end

  // reference derived from the requirements
  int m_cnt = 0;
  logic m_err = 1'b1;
  logic [N-1:0] m_en = '0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_err = 1'b1; m_en = '0;
    end else if (srst) begin
      m_cnt = 0; m_err = 1'b1; m_en = '0;
    end else begin
      for (int i = 0; i < N; i++) if (!src[i]) m_en[i] = !m_err;
      if (!pres || !lock) m_cnt = 0;
      else if (tick && m_cnt < Q) m_cnt++;
      m_err = (m_cnt != Q) || (m_err && hold);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(err == m_err, "R3 R6 model err", err, m_err);
    chk(gclk == (src & m_en), "R7 gated", gclk, src & m_en);
  end

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 50000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc_n, 50000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc(input logic t, input logic p, input logic l, input logic h);
    tick = t; pres = p; lock = l; hold = h;
    @(negedge clk); #1;
  endtask

  task automatic fault_cycle(input logic h);
    cyc(0, 0, 1, h);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    chk(err == 1'b1, "R1 err after reset", err, 1);
    chk(gclk == '0, "R1 clocks low after reset", gclk, 0);

    // R10: clean stream without ticks never qualifies
    for (int i = 0; i < 8; i++) begin
      cyc(0, 1, 1, 0);
      chk(err == 1'b1, "R10 no tick", err, 1);
    end

    // R3: release exactly on the Q-th clean tick
    for (int k = 1; k <= Q; k++) begin
      cyc(1, 1, 1, 0);
      chk(err == (k < Q), "R3 release point", err, k < Q);
      cyc(0, 1, 1, 0);
    end

    // R9: saturation keeps err low
    for (int i = 0; i < 3 * Q; i++) begin
      cyc(1, 1, 1, 0);
      chk(err == 1'b0, "R9 stays good", err, 0);
    end
    repeat (4) cyc(0, 1, 1, 0);
    chk(gclk == src, "R7 gate open when good", gclk, src);

    // R2: missing stream, then lost lock
    cyc(0, 0, 1, 0);
    chk(err == 1'b1, "R2 no stream", err, 1);
    cyc(0, 1, 1, 0);
    cyc(0, 1, 0, 0);
    chk(err == 1'b1, "R2 lock lost", err, 1);
    repeat (3) cyc(0, 1, 1, 0);
    chk(gclk == '0, "R7 gate closed on error", gclk, 0);

    // R4: single fault at every point of a partial run
    for (int p = 1; p < Q; p++) begin
      fault_cycle(0);
      for (int j = 0; j < p; j++) begin
        cyc(1, 1, 1, 0);
        chk(err == 1'b1, "R4 partial run", err, 1);
      end
      fault_cycle(0);
      chk(err == 1'b1, "R4 fault in run", err, 1);
      for (int k = 1; k <= Q; k++) begin
        cyc(1, 1, 1, 0);
        chk(err == (k < Q), "R4 full recount", err, k < Q);
      end
    end

    // R5: hold keeps error past qualification
    fault_cycle(1);
    for (int k = 1; k <= Q + 3; k++) begin
      cyc(1, 1, 1, 1);
      chk(err == 1'b1, "R5 held", err, 1);
    end
    cyc(0, 1, 1, 0);
    chk(err == 1'b0, "R5 release on hold low", err, 0);

    // R5: hold dropped mid-run releases at Q-th tick
    fault_cycle(1);
    for (int k = 1; k <= Q; k++) begin
      cyc(1, 1, 1, (k < 3));
      chk(err == (k < Q), "R5 hold dropped early", err, k < Q);
    end

    // R6: follows fault with hold low
    fault_cycle(0);
    chk(err == 1'b1, "R6 fault raises", err, 1);
    for (int k = 1; k <= Q; k++) begin
      cyc(1, 1, 1, 0);
      chk(err == (k < Q), "R6 recovers", err, k < Q);
    end

    // R8: sync reset discards qualification
    repeat (4) cyc(0, 1, 1, 0);
    srst = 1'b1;
    cyc(0, 1, 1, 0);
    srst = 1'b0;
    chk(err == 1'b1, "R1 R8 err after sync reset", err, 1);
    chk(gclk == '0, "R1 clocks after sync reset", gclk, 0);
    for (int k = 1; k <= Q; k++) begin
      cyc(1, 1, 1, 0);
      chk(err == (k < Q), "R8 recount after sync reset", err, k < Q);
    end

    repeat (4) cyc(0, 1, 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule